// File: doc/BRIEF.md
# DTMF Tone Validation Steering

This block sits behind a tone-pair detector and decides when a detected tone pair counts as a received digit. The detector supplies a raw "tone present" level and a 4-bit digit code. The block registers a digit only after the raw level has stayed high for a programmable number of sampling-clock cycles. At that point it captures the code and raises a guard output. Two cycles later it raises a delayed steering flag, which can also pull an active-low interrupt.

The release side uses a second programmable guard. The flag clears, and an interdigit pause is declared, only when the tone has been absent for long enough. Shorter gaps count as a continuing tone, so the captured code and the flag are left untouched. Both guards are 16-bit cycle counts supplied as inputs.

The controller is a five-state machine:
- IDLE waits for tone.
- QUALIFY times the tone-present guard.
- SETTLE waits the fixed two-cycle settling delay.
- HOLD means a digit is registered and the tone is still present.
- DROPOUT times the tone-absent guard.

The transitions are:
- IDLE→QUALIFY when tone is seen.
- QUALIFY→IDLE when tone is lost early.
- QUALIFY→SETTLE when the present guard expires; the code is latched here.
- SETTLE→HOLD or SETTLE→DROPOUT when the delay ends, depending on whether tone is present.
- HOLD→DROPOUT when tone is lost.
- DROPOUT→HOLD when tone returns.
- DROPOUT→IDLE when the absent guard expires.

Top module: `dtmf_steer`

## Requirements
- R1: A tone burst seen high on fewer than present_guard+2 consecutive sampling edges registers nothing. guard_out and steer_flag stay low, and digit_out keeps its previous value.
- R2: On the (present_guard+2)th consecutive edge with tone_raw high, digit_in is copied to digit_out. digit_out changes at no other time, even if digit_in changes while the tone is held.
- R3: guard_out goes high in the cycle the code is latched. It stays high until tone_raw is first seen low after the settling delay. It returns high when tone comes back within the absent guard window.
- R4: steer_flag rises exactly two clock cycles after the code latch.
- R5: irq_n is low exactly when irq_en is 1 and steer_flag is 1; otherwise it is high.
- R6: steer_flag clears only after absent_guard+2 consecutive edges with tone_raw low. A shorter dropout leaves steer_flag high and digit_out unchanged.
- R7: With a guard value of zero, two consecutive high edges register a digit, and two consecutive low edges clear the flag.
- R8: All four code bits are passed through unaltered. The digit encoding is: 1–9 as 0001–1001, 0 as 1010, * as 1011, # as 1100, A/B/C as 1101/1110/1111, and D as 0000.
- R9: Synchronous active-high reset sets the state to IDLE, clears digit_out to 0000, drives steer_flag and guard_out low, and drives irq_n high.
- R10: After a pause has been declared, a new tone must qualify afresh and then latches its own code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| tone_raw | input | 1 | Raw tone-pair-present level from the detector |
| digit_in | input | 4 | Digit code from the detector |
| present_guard | input | 16 | Tone-present guard in cycles |
| absent_guard | input | 16 | Tone-absent guard in cycles |
| irq_en | input | 1 | Interrupt enable |
| digit_out | output | 4 | Latched digit code |
| steer_flag | output | 1 | Delayed steering flag |
| guard_out | output | 1 | Guard output, high while a validated tone persists |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench keeps the default parameters: 16-bit guard counts and the two-cycle settling delay. It drives the guard inputs with 0, 2 and 3. Small guards place the exact accept and reject edges a few cycles apart, so every count boundary can be hit one edge early and exactly on time. The zero guard exercises the shortest qualification and release the counter allows.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_QUALIFY = 3'd1,
        ST_SETTLE  = 3'd2,
        ST_HOLD    = 3'd3,
        ST_DROPOUT = 3'd4
    } steer_state_e;
endpackage

// File: rtl/steer_guard_timer.sv
module steer_guard_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt >= limit);
endmodule

// File: rtl/dtmf_steer.sv
module dtmf_steer
    import dtmf_steer_pkg::*;
#(
    parameter int GUARD_W    = 16,
    parameter int CODE_W     = 4,
    parameter int SETTLE_CYC = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tone_raw,
    input  logic [CODE_W-1:0]  digit_in,
    input  logic [GUARD_W-1:0] present_guard,
    input  logic [GUARD_W-1:0] absent_guard,
    input  logic               irq_en,
    output logic [CODE_W-1:0]  digit_out,
    output logic               steer_flag,
    output logic               guard_out,
    output logic               irq_n
);
    localparam logic [GUARD_W-1:0] SETTLE_LIM = GUARD_W'(SETTLE_CYC - 1);

    steer_state_e state_q, state_d;
    logic               tmr_clr, tmr_inc, tmr_exp, latch_en;
    logic [GUARD_W-1:0] tmr_limit;

    steer_guard_timer #(.CNT_W(GUARD_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .inc     (tmr_inc),
        .limit   (tmr_limit),
        .expired (tmr_exp)
    );

    // Limit for the timer depends on which interval is being timed
    always_comb begin
        unique case (state_q)
            ST_QUALIFY: tmr_limit = present_guard;
            ST_DROPOUT: tmr_limit = absent_guard;
            ST_SETTLE:  tmr_limit = SETTLE_LIM;
            default:    tmr_limit = '0;
        endcase
    end

    // Next-state and timer control
    always_comb begin
        state_d  = state_q;
        tmr_clr  = 1'b0;
        tmr_inc  = 1'b0;
        latch_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                tmr_clr = 1'b1;
                if (tone_raw) state_d = ST_QUALIFY;
            end
            ST_QUALIFY: begin
                if (!tone_raw) begin
                    state_d = ST_IDLE;
                    tmr_clr = 1'b1;
                end else if (tmr_exp) begin
                    state_d  = ST_SETTLE;
                    tmr_clr  = 1'b1;
                    latch_en = 1'b1;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tmr_exp) begin
                    state_d = tone_raw ? ST_HOLD : ST_DROPOUT;
                    tmr_clr = 1'b1;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            ST_HOLD: begin
                tmr_clr = 1'b1;
                if (!tone_raw) state_d = ST_DROPOUT;
            end
            ST_DROPOUT: begin
                if (tone_raw) begin
                    state_d = ST_HOLD;
                    tmr_clr = 1'b1;
                end else if (tmr_exp) begin
                    state_d = ST_IDLE;
                    tmr_clr = 1'b1;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                tmr_clr = 1'b1;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Output process: code latch and state decode
    always_ff @(posedge clk) begin
        if (rst)           digit_out <= '0;
        else if (latch_en) digit_out <= digit_in;
    end

    always_comb begin
        steer_flag = (state_q == ST_HOLD) || (state_q == ST_DROPOUT);
        guard_out  = (state_q == ST_SETTLE) || (state_q == ST_HOLD);
        irq_n      = ~(irq_en & steer_flag);
    end
endmodule

// File: rtl/dtmf_steer_chk.sv
module dtmf_steer_chk #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              tone_raw,
    input logic              irq_en,
    input logic [CODE_W-1:0] digit_out,
    input logic              steer_flag,
    input logic              guard_out,
    input logic              irq_n
);
    AST_CODE_ONLY_AT_GUARD: assert property (@(posedge clk) disable iff (rst)
        !$stable(digit_out) |-> $rose(guard_out)); // R2

    AST_GUARD_RISE_WITH_TONE: assert property (@(posedge clk) disable iff (rst)
        $rose(guard_out) |-> $past(tone_raw)); // R3

    AST_FLAG_TWO_AFTER_GUARD: assert property (@(posedge clk) disable iff (rst)
        $rose(steer_flag) |-> ($past(guard_out) && $past(guard_out, 2))); // R4

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (steer_flag && irq_en)); // R5

    AST_FLAG_FALL_AFTER_ABSENCE: assert property (@(posedge clk) disable iff (rst)
        $fell(steer_flag) |-> (!$past(tone_raw) && !$past(tone_raw, 2))); // R6
endmodule

bind dtmf_steer dtmf_steer_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tone_raw   (tone_raw),
    .irq_en     (irq_en),
    .digit_out  (digit_out),
    .steer_flag (steer_flag),
    .guard_out  (guard_out),
    .irq_n      (irq_n)
);

// File: tb/tb_dtmf_steer.sv
module tb_dtmf_steer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tone_raw = 1'b0;
    logic [3:0]  digit_in = '0;
    logic [15:0] present_guard = 16'd3;
    logic [15:0] absent_guard = 16'd2;
    logic        irq_en = 1'b1;
    logic [3:0]  digit_out;
    logic        steer_flag, guard_out, irq_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dtmf_steer dut (
        .clk(clk), .rst(rst), .tone_raw(tone_raw), .digit_in(digit_in),
        .present_guard(present_guard), .absent_guard(absent_guard),
        .irq_en(irq_en), .digit_out(digit_out), .steer_flag(steer_flag),
        .guard_out(guard_out), .irq_n(irq_n)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic t_reset();
        chk("R9", "digit_out", digit_out, 0);
        chk("R9", "steer_flag", steer_flag, 0);
        chk("R9", "guard_out", guard_out, 0);
        chk("R9", "irq_n", irq_n, 1);
    endtask

    task automatic t_short_burst();
        present_guard = 16'd3; digit_in = 4'b0101; tone_raw = 1'b1;
        edges(4);
        chk("R1", "guard after 4 edges", guard_out, 0);
        tone_raw = 1'b0;
        edges(3);
        chk("R1", "flag after short burst", steer_flag, 0);
        chk("R1", "code after short burst", digit_out, 0);
    endtask

    task automatic t_accept(input logic [3:0] code);
        present_guard = 16'd3; digit_in = code; irq_en = 1'b1; tone_raw = 1'b1;
        edges(4);
        chk("R2", "guard one edge early", guard_out, 0);
        edges(1);
        chk("R3", "guard at latch", guard_out, 1);
        chk("R2", "code at latch", digit_out, code);
        chk("R4", "flag at latch", steer_flag, 0);
        digit_in = ~code;
        edges(1);
        chk("R4", "flag latch+1", steer_flag, 0);
        edges(1);
        chk("R4", "flag latch+2", steer_flag, 1);
        chk("R5", "irq_n with flag", irq_n, 0);
        edges(3);
        chk("R2", "code held while input changes", digit_out, code);
        chk("R8", "code bits", digit_out, code);
    endtask

    task automatic t_dropout(input logic [3:0] code);
        absent_guard = 16'd2; tone_raw = 1'b0;
        edges(1);
        chk("R3", "guard on absence", guard_out, 0);
        edges(2);
        chk("R6", "flag during short dropout", steer_flag, 1);
        tone_raw = 1'b1;
        edges(1);
        chk("R3", "guard back after dropout", guard_out, 1);
        chk("R6", "code after dropout", digit_out, code);
    endtask

    task automatic t_release(input logic [3:0] code);
        absent_guard = 16'd2; tone_raw = 1'b0;
        edges(3);
        chk("R6", "flag one edge early", steer_flag, 1);
        edges(1);
        chk("R6", "flag cleared", steer_flag, 0);
        chk("R5", "irq_n after clear", irq_n, 1);
        chk("R6", "code kept after pause", digit_out, code);
    endtask

    task automatic t_zero_guard();
        present_guard = 16'd0; absent_guard = 16'd0; digit_in = 4'b1010;
        tone_raw = 1'b1;
        edges(1);
        chk("R7", "no latch after one edge", guard_out, 0);
        tone_raw = 1'b0;
        edges(2);
        chk("R7", "one-edge pulse rejected", digit_out, 4'b1111);
        tone_raw = 1'b1;
        edges(2);
        chk("R7", "latch after two edges", digit_out, 4'b1010);
        edges(2);
        chk("R7", "flag up", steer_flag, 1);
        tone_raw = 1'b0;
        edges(1);
        chk("R7", "flag after one low edge", steer_flag, 1);
        edges(1);
        chk("R7", "flag after two low edges", steer_flag, 0);
    endtask

    task automatic t_irq_off();
        present_guard = 16'd2; absent_guard = 16'd2; irq_en = 1'b0;
        digit_in = 4'b0000; tone_raw = 1'b1;
        edges(6);
        chk("R10", "new digit latched", digit_out, 0);
        chk("R5", "flag up irq disabled", steer_flag, 1);
        chk("R5", "irq_n disabled", irq_n, 1);
        irq_en = 1'b1;
        #1;
        chk("R5", "irq_n enabled", irq_n, 0);
        tone_raw = 1'b0;
        edges(5);
    endtask

    initial begin
        @(negedge clk);
        edges(2);
        rst = 1'b0;
        t_reset();
        t_short_burst();
        t_accept(4'b1111);
        t_dropout(4'b1111);
        t_release(4'b1111);
        t_zero_guard();
        t_irq_off();
        t_accept(4'b0011);
        t_release(4'b0011);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule